// File: doc/BRIEF.md
# Dual Byte-Counted FIFO Pair

This block sits between a register bus and a serial interface engine and holds two word-wide FIFOs of 32 bytes each. The outgoing FIFO takes 32-bit words pushed by the host and hands them to the engine one byte at a time. The incoming FIFO collects single bytes from the engine and returns them to the host as 32-bit words. Occupancy and free space are counted in bytes for both FIFOs, while the host always moves whole words.

Each direction has a programmable byte threshold that raises a level condition. A zero threshold turns that condition off. Pushing into a full outgoing FIFO and popping an empty incoming FIFO are both flagged. A control input selects whether a host pop happens on a read strobe or on a separate write strobe with discarded data. A level-sensitive, active-low software reset empties both FIFOs. Flags collect in a sticky status vector with per-bit enables, write-1-to-clear inputs and one combined interrupt output.

Top module: `dual_byte_fifo`

## Requirements
- R1: Each `push_i` strobe with at least 4 free bytes stores `push_data_i` and raises `tx_used_o` by 4 and lowers `tx_free_o` by 4. The engine receives the bytes of each word lane 0 (bits 7:0) first, then lanes 1, 2 and 3, on `tx_byte_o`.
- R2: An engine byte offered on `rx_valid_i` while `rx_ready_o` is 1 raises `rx_used_o` by 1. Bytes are packed into words lane 0 first, and `pop_data_o` always shows the word at the incoming read position.
- R3: With `pop_on_wr_i` = 0, a `pop_rd_i` strobe removes one word, and `pop_wr_i` has no effect on the incoming FIFO.
- R4: With `pop_on_wr_i` = 1, a `pop_wr_i` strobe removes one word, and `pop_rd_i` has no effect on the incoming FIFO.
- R5: A pop while `rx_used_o` is 1 to 3 returns those bytes in the low lanes and empties the FIFO. `rx_ready_o` is 0 in that cycle, and the next engine byte lands in lane 0 of the following word.
- R6: Status bit 0 sets while `wthr_i` is non-zero and `tx_free_o` >= `wthr_i`. Status bit 1 sets while `rthr_i` is non-zero and `rx_used_o` >= `rthr_i`. A threshold of 0 never sets its bit.
- R7: A push with fewer than 4 free bytes leaves the outgoing contents and counts unchanged, and it sets status bits 2 (overflow) and 4 (illegal access).
- R8: A pop while `rx_used_o` is 0 leaves the counts unchanged, and it sets status bits 3 (underflow) and 4 (illegal access).
- R9: Status bits are sticky until a 1 on the matching `irq_clr_i` bit clears them. A set in the same cycle wins over a clear. `irq_o` is the OR of `irq_status_o & irq_en_i`.
- R10: While `fifo_rst_n_i` is 0, both FIFOs are empty (`tx_used_o` = `rx_used_o` = 0, both free counts 32), `tx_valid_o` and `rx_ready_o` are 0, and push, pop and engine strobes have no effect. Operation resumes when it returns to 1.
- R11: `tx_valid_o` is 1 exactly when `tx_used_o` is non-zero. `tx_ready_i` while `tx_valid_o` is 0 changes nothing. `rx_ready_o` is 0 while `rx_used_o` is 32, and a byte offered then is dropped.
- R12: After `rst_ni` is released, both FIFOs are empty, all status bits are 0, `irq_o` is 0 and `rx_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_rst_n_i | input | 1 | Software FIFO reset, active low, level held |
| pop_on_wr_i | input | 1 | 1: pop on `pop_wr_i`; 0: pop on `pop_rd_i` |
| wthr_i | input | 6 | Outgoing free-byte threshold, 0 disables |
| rthr_i | input | 6 | Incoming valid-byte threshold, 0 disables |
| push_i | input | 1 | Host write strobe to the push register |
| push_data_i | input | 32 | Word to push |
| pop_rd_i | input | 1 | Host read strobe of the pop register |
| pop_wr_i | input | 1 | Host write strobe of the pop register (data discarded) |
| pop_data_o | output | 32 | Word at the incoming read position |
| tx_byte_o | output | 8 | Next outgoing byte for the engine |
| tx_valid_o | output | 1 | Outgoing byte available |
| tx_ready_i | input | 1 | Engine takes the outgoing byte |
| rx_byte_i | input | 8 | Incoming byte from the engine |
| rx_valid_i | input | 1 | Engine offers an incoming byte |
| rx_ready_o | output | 1 | Incoming byte accepted this cycle |
| tx_used_o | output | 6 | Valid bytes in the outgoing FIFO |
| tx_free_o | output | 6 | Free bytes in the outgoing FIFO |
| rx_used_o | output | 6 | Valid bytes in the incoming FIFO |
| rx_free_o | output | 6 | Free bytes in the incoming FIFO |
| irq_en_i | input | 5 | Per-bit interrupt enables |
| irq_clr_i | input | 5 | Write-1-to-clear strobes for status bits |
| irq_status_o | output | 5 | Sticky status: 0 wthr, 1 rthr, 2 overflow, 3 underflow, 4 illegal access |
| irq_o | output | 1 | OR of enabled status bits |

## Verification
The assertions assume that the host asserts each strobe for a single cycle per register access. They also assume that an engine byte is counted only in a cycle where `rx_ready_o` is 1. The pop-mode and partial-pop properties further assume that no engine byte is offered in the same cycle. The stimulus follows these rules by driving every strobe for one cycle between falling edges. It offers a byte to a full FIFO only in the dedicated drop check, and it offers a byte during a partial pop only to observe `rx_ready_o`. The threshold sweeps vary the level by single bytes and compare every threshold from 0 to 33 against the level.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = 8 * LANES;
  localparam int unsigned IRQ_N  = 5;

  localparam int unsigned IRQ_WTHR = 0;
  localparam int unsigned IRQ_RTHR = 1;
  localparam int unsigned IRQ_OVF  = 2;
  localparam int unsigned IRQ_UDF  = 3;
  localparam int unsigned IRQ_IACC = 4;

  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/dbf_tx_fifo.sv
module dbf_tx_fifo
  import dbf_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 8,
  localparam int unsigned DEPTH_B = DEPTH_WORDS * LANES,
  localparam int unsigned CNT_W   = $clog2(DEPTH_B + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [7:0]        byte_o,
  output logic [CNT_W-1:0]  used_o,
  output logic [CNT_W-1:0]  free_o,
  output logic              ovf_o
);
  localparam int unsigned PTR_W  = $clog2(DEPTH_B);
  localparam int unsigned WPTR_W = PTR_W - 2;

  logic [7:0]        mem_q [DEPTH_B];
  logic [WPTR_W-1:0] wr_q;
  logic [PTR_W-1:0]  rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  assign free_o  = CNT_W'(DEPTH_B) - cnt_q;
  assign used_o  = cnt_q;
  assign push_ok = push_i && (free_o >= CNT_W'(LANES));
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign ovf_o   = push_i && !push_ok;
  assign byte_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      for (int b = 0; b < LANES; b++) mem_q[{wr_q, 2'(b)}] <= push_data_i[8*b +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + WPTR_W'(push_ok);
      rd_q  <= rd_q + PTR_W'(pop_ok);
      cnt_q <= cnt_q + (push_ok ? CNT_W'(LANES) : '0) - CNT_W'(pop_ok);
    end
  end

  AST_TX_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && push_i && free_o >= CNT_W'(LANES) && !pop_i) |=> used_o == $past(used_o) + CNT_W'(LANES)); // R1
  AST_TX_OVF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && push_i && free_o < CNT_W'(LANES) && !pop_i) |=> $stable(used_o)); // R7
  AST_TX_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && pop_i && used_o == '0 && !push_i) |=> used_o == '0); // R11
  AST_TX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= CNT_W'(DEPTH_B)); // R11
endmodule

// File: rtl/dbf_rx_fifo.sv
module dbf_rx_fifo
  import dbf_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 8,
  localparam int unsigned DEPTH_B = DEPTH_WORDS * LANES,
  localparam int unsigned CNT_W   = $clog2(DEPTH_B + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [7:0]        wr_byte_i,
  output logic              ready_o,
  input  logic              pop_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  used_o,
  output logic [CNT_W-1:0]  free_o,
  output logic              udf_o
);
  localparam int unsigned PTR_W  = $clog2(DEPTH_B);
  localparam int unsigned WPTR_W = PTR_W - 2;

  logic [7:0]        mem_q [DEPTH_B];
  logic [PTR_W-1:0]  wr_q;
  logic [WPTR_W-1:0] rd_q;
  logic [CNT_W-1:0]  cnt_q, take_w;
  logic              pop_ok, partial, wr_ok;

  assign used_o  = cnt_q;
  assign free_o  = CNT_W'(DEPTH_B) - cnt_q;
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign partial = pop_ok && (cnt_q < CNT_W'(LANES));
  // a partial pop realigns the write side, so hold the engine off for that cycle
  assign ready_o = (cnt_q != CNT_W'(DEPTH_B)) && !partial;
  assign wr_ok   = wr_i && ready_o;
  assign udf_o   = pop_i && (cnt_q == '0);
  assign take_w  = partial ? cnt_q : CNT_W'(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[8*g +: 8] = mem_q[{rd_q, 2'(g)}];
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_q] <= wr_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= partial ? {rd_q + WPTR_W'(1), 2'b00} : wr_q + PTR_W'(wr_ok);
      rd_q  <= rd_q + WPTR_W'(pop_ok);
      cnt_q <= cnt_q + CNT_W'(wr_ok) - (pop_ok ? take_w : '0);
    end
  end

  AST_RX_WR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wr_i && ready_o && !pop_i) |=> used_o == $past(used_o) + CNT_W'(1)); // R2
  AST_RX_PARTIAL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && pop_i && used_o != '0 && used_o < CNT_W'(LANES)) |=> used_o == '0); // R5
  AST_RX_UDF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && pop_i && used_o == '0 && !wr_i) |=> used_o == '0); // R8
  AST_RX_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && used_o == CNT_W'(DEPTH_B) && !pop_i) |=> used_o == CNT_W'(DEPTH_B)); // R11
endmodule

// File: rtl/dbf_irq.sv
module dbf_irq
  import dbf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  irq_vec_t set_i,
  input  irq_vec_t clr_i,
  input  irq_vec_t en_i,
  output irq_vec_t status_o,
  output logic     irq_o
);
  irq_vec_t status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & en_i);

  for (genvar g = 0; g < IRQ_N; g++) begin : g_chk
    AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[g] && !clr_i[g]) |=> status_q[g]); // R9
    AST_IRQ_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> status_q[g]); // R9
    AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !status_q[g]); // R9
  end
endmodule

// File: rtl/dual_byte_fifo.sv
module dual_byte_fifo
  import dbf_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH_WORDS * LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_rst_n_i,
  input  logic              pop_on_wr_i,
  input  logic [CNT_W-1:0]  wthr_i,
  input  logic [CNT_W-1:0]  rthr_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_rd_i,
  input  logic              pop_wr_i,
  output logic [WORD_W-1:0] pop_data_o,
  output logic [7:0]        tx_byte_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [CNT_W-1:0]  tx_used_o,
  output logic [CNT_W-1:0]  tx_free_o,
  output logic [CNT_W-1:0]  rx_used_o,
  output logic [CNT_W-1:0]  rx_free_o,
  input  logic [IRQ_N-1:0]  irq_en_i,
  input  logic [IRQ_N-1:0]  irq_clr_i,
  output logic [IRQ_N-1:0]  irq_status_o,
  output logic              irq_o
);
  logic     run, pop_req, rx_rdy, ovf, udf;
  irq_vec_t set_w;

  assign run     = fifo_rst_n_i;
  assign pop_req = run && (pop_on_wr_i ? pop_wr_i : pop_rd_i);

  dbf_tx_fifo #(.DEPTH_WORDS(DEPTH_WORDS)) u_tx (
    .clk_i, .rst_ni,
    .clr_i       (!run),
    .push_i      (push_i && run),
    .push_data_i,
    .pop_i       (tx_ready_i && run),
    .byte_o      (tx_byte_o),
    .used_o      (tx_used_o),
    .free_o      (tx_free_o),
    .ovf_o       (ovf)
  );

  dbf_rx_fifo #(.DEPTH_WORDS(DEPTH_WORDS)) u_rx (
    .clk_i, .rst_ni,
    .clr_i     (!run),
    .wr_i      (rx_valid_i && run),
    .wr_byte_i (rx_byte_i),
    .ready_o   (rx_rdy),
    .pop_i     (pop_req),
    .word_o    (pop_data_o),
    .used_o    (rx_used_o),
    .free_o    (rx_free_o),
    .udf_o     (udf)
  );

  assign tx_valid_o = run && (tx_used_o != '0);
  assign rx_ready_o = run && rx_rdy;

  always_comb begin
    set_w           = '0;
    set_w[IRQ_WTHR] = (wthr_i != '0) && (tx_free_o >= wthr_i);
    set_w[IRQ_RTHR] = (rthr_i != '0) && (rx_used_o >= rthr_i);
    set_w[IRQ_OVF]  = ovf;
    set_w[IRQ_UDF]  = udf;
    set_w[IRQ_IACC] = ovf || udf;
  end

  dbf_irq u_irq (
    .clk_i, .rst_ni,
    .set_i    (set_w),
    .clr_i    (irq_clr_i),
    .en_i     (irq_en_i),
    .status_o (irq_status_o),
    .irq_o
  );

  AST_SOFT_RST_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_rst_n_i |=> (tx_used_o == '0 && rx_used_o == '0)); // R10
  AST_POP_RD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_on_wr_i && pop_rd_i && !pop_wr_i && !rx_valid_i) |=> $stable(rx_used_o)); // R4
  AST_POP_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_on_wr_i && pop_wr_i && !pop_rd_i && !rx_valid_i) |=> $stable(rx_used_o)); // R3
  AST_ZERO_THR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wthr_i == '0 && rthr_i == '0 && irq_clr_i[IRQ_WTHR] && irq_clr_i[IRQ_RTHR])
      |=> (!irq_status_o[IRQ_WTHR] && !irq_status_o[IRQ_RTHR])); // R6
endmodule

// File: tb/dual_byte_fifo_test.sv
`timescale 1ns/1ps
module dual_byte_fifo_test;
  logic        clk_i = 0, rst_ni = 0, fifo_rst_n_i = 1, pop_on_wr_i = 0;
  logic [5:0]  wthr_i = 0, rthr_i = 0;
  logic        push_i = 0, pop_rd_i = 0, pop_wr_i = 0;
  logic [31:0] push_data_i = 0, pop_data_o;
  logic [7:0]  tx_byte_o, rx_byte_i = 0;
  logic        tx_valid_o, tx_ready_i = 0, rx_valid_i = 0, rx_ready_o;
  logic [5:0]  tx_used_o, tx_free_o, rx_used_o, rx_free_o;
  logic [4:0]  irq_en_i = 0, irq_clr_i = 0, irq_status_o;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  dual_byte_fifo uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic push_word(logic [31:0] w);
    push_i = 1; push_data_i = w; cyc(); push_i = 0;
  endtask

  task automatic rx_send(logic [7:0] b);
    rx_valid_i = 1; rx_byte_i = b; cyc(); rx_valid_i = 0;
  endtask

  task automatic pop_rd(); pop_rd_i = 1; cyc(); pop_rd_i = 0; endtask
  task automatic pop_wr(); pop_wr_i = 1; cyc(); pop_wr_i = 0; endtask

  function automatic logic [31:0] mk_word(logic [7:0] base);
    return {base + 8'd3, base + 8'd2, base + 8'd1, base};
  endfunction

  task automatic sweep(bit is_rx, int level);
    for (int thr = 0; thr <= 33; thr++) begin
      if (is_rx) begin rthr_i = 6'(thr); irq_clr_i = 5'b00010; end
      else       begin wthr_i = 6'(thr); irq_clr_i = 5'b00001; end
      cyc();
      irq_clr_i = 0;
      check("R6", {31'd0, irq_status_o[is_rx ? 1 : 0]}, {31'd0, (thr != 0) && (level >= thr)});
    end
    wthr_i = 0; rthr_i = 0; irq_clr_i = 5'b00011; cyc(); irq_clr_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_ni = 1;
    cyc();
    // R12 reset state
    check("R12", tx_used_o, 0);
    check("R12", tx_free_o, 32);
    check("R12", rx_used_o, 0);
    check("R12", rx_free_o, 32);
    check("R12", irq_status_o, 0);
    check("R12", irq_o, 0);
    check("R12", rx_ready_o, 1);
    check("R11", tx_valid_o, 0);

    // R1 fill outgoing FIFO
    for (int k = 0; k < 8; k++) begin
      push_word(mk_word(8'(8'h10 + 4 * k)));
      check("R1", tx_used_o, 4 * (k + 1));
      check("R1", tx_free_o, 32 - 4 * (k + 1));
    end
    // R7 overflow
    irq_clr_i = 5'b11111; cyc(); irq_clr_i = 0;
    push_word(32'hDEADBEEF);
    check("R7", tx_used_o, 32);
    check("R7", irq_status_o[2], 1);
    check("R7", irq_status_o[4], 1);
    // R1 drain byte by byte, with R6 write-threshold sweep at each level
    for (int i = 0; i < 32; i++) begin
      sweep(0, i);
      check("R11", tx_valid_o, 1);
      check("R1", tx_byte_o, 8'(8'h10 + i));
      tx_ready_i = 1; cyc(); tx_ready_i = 0;
      check("R1", tx_used_o, 31 - i);
    end
    sweep(0, 32);
    check("R11", tx_valid_o, 0);
    tx_ready_i = 1; cyc(); tx_ready_i = 0;
    check("R11", tx_used_o, 0);
    check("R11", tx_free_o, 32);

    irq_clr_i = 5'b11111; cyc(); irq_clr_i = 0;
    check("R9", irq_status_o, 0);

    // R2 fill incoming FIFO, R6 read-threshold sweep
    for (int i = 0; i < 32; i++) begin
      sweep(1, i);
      check("R2", rx_ready_o, 1);
      rx_send(8'(8'hA0 + i));
      check("R2", rx_used_o, i + 1);
    end
    sweep(1, 32);
    check("R11", rx_ready_o, 0);
    rx_send(8'h55);
    check("R11", rx_used_o, 32);
    check("R2", pop_data_o, mk_word(8'hA0));

    // R3 pop on read
    pop_wr();
    check("R3", rx_used_o, 32);
    pop_rd();
    check("R3", rx_used_o, 28);
    check("R3", rx_free_o, 4);
    check("R2", pop_data_o, mk_word(8'hA4));

    // R4 pop on write
    pop_on_wr_i = 1;
    pop_rd();
    check("R4", rx_used_o, 28);
    for (int k = 1; k < 8; k++) begin
      check("R4", pop_data_o, mk_word(8'(8'hA0 + 4 * k)));
      pop_wr();
      check("R4", rx_used_o, 28 - 4 * k);
    end
    // R8 underflow
    irq_clr_i = 5'b11111; cyc(); irq_clr_i = 0;
    pop_wr();
    check("R8", rx_used_o, 0);
    check("R8", irq_status_o[3], 1);
    check("R8", irq_status_o[4], 1);
    check("R8", irq_status_o[2], 0);
    pop_on_wr_i = 0;

    // R5 partial-word pops
    for (int k = 1; k <= 3; k++) begin
      for (int j = 0; j < k; j++) rx_send(8'(8'h50 + 8 * k + j));
      check("R5", rx_used_o, k);
      for (int j = 0; j < k; j++) check("R5", pop_data_o[8*j +: 8], 8'(8'h50 + 8 * k + j));
      pop_rd_i = 1; rx_valid_i = 1; rx_byte_i = 8'hEE;
      #1;
      check("R5", rx_ready_o, 0);
      cyc();
      pop_rd_i = 0; rx_valid_i = 0;
      check("R5", rx_used_o, 0);
      check("R5", rx_free_o, 32);
      rx_send(8'h77);
      check("R5", rx_used_o, 1);
      check("R5", pop_data_o[7:0], 8'h77);
      pop_rd();
      check("R5", rx_used_o, 0);
    end

    // R9 sticky, enable, set-over-clear
    irq_clr_i = 5'b11111; cyc(); irq_clr_i = 0;
    for (int k = 0; k < 8; k++) push_word(mk_word(8'(8'h30 + 4 * k)));
    irq_en_i = 5'b00100; cyc();
    check("R9", irq_o, 0);
    push_word(32'h0);
    check("R9", irq_status_o[2], 1);
    check("R9", irq_o, 1);
    cyc(); cyc(); cyc();
    check("R9", irq_status_o[2], 1);
    irq_en_i = 5'b01011; #1;
    check("R9", irq_o, 0);
    irq_en_i = 5'b00100;
    irq_clr_i = 5'b00100; push_i = 1; cyc(); irq_clr_i = 0; push_i = 0;
    check("R9", irq_status_o[2], 1);
    irq_clr_i = 5'b00100; cyc(); irq_clr_i = 0;
    check("R9", irq_status_o[2], 0);
    check("R9", irq_status_o[4], 1);
    check("R9", irq_o, 0);

    // R10 software reset
    rx_send(8'h11);
    fifo_rst_n_i = 0; cyc();
    check("R10", tx_used_o, 0);
    check("R10", tx_free_o, 32);
    check("R10", rx_used_o, 0);
    check("R10", rx_free_o, 32);
    check("R10", tx_valid_o, 0);
    check("R10", rx_ready_o, 0);
    irq_clr_i = 5'b11111; cyc(); irq_clr_i = 0;
    push_word(32'h12345678);
    rx_send(8'h22);
    pop_rd();
    check("R10", tx_used_o, 0);
    check("R10", rx_used_o, 0);
    check("R10", irq_status_o, 0);
    fifo_rst_n_i = 1; cyc();
    push_word(32'hCAFEF00D);
    check("R10", tx_used_o, 4);
    check("R10", tx_byte_o, 8'h0D);
    rx_send(8'h99);
    check("R10", rx_used_o, 1);
    check("R10", pop_data_o[7:0], 8'h99);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule